// File: doc/BRIEF.md
# Task-Event UART Register Controller

This block is the register front end of a simple serial port. Software drives it over a 32-bit, word-addressed bus with a single-cycle write strobe and a read strobe whose data is registered. It never sees a status word. It writes the value 1 to separate task words to start or stop the transmitter and the receiver. It then watches four latched event flags: received byte available, transmit byte finished, line error and receiver stopped. Each flag can be routed to one level interrupt through an enable mask. Software can write that mask whole, set bits in it or clear bits in it.

The serial engine sits on the other side of the block. It takes a pending byte through `tx_req`/`tx_byte` and reports the end of that byte with `tx_done`. It offers received bytes through `rx_valid`/`rx_byte`, which the block queues in a small FIFO, and it reports a break on the line with `line_break`. A global enable gate turns the whole register window off. Only the single value 4 opens the gate. The block stores the baud and pin-select words but does not interpret them.

Top module: `tevu_ctrl`

## Requirements
- R1: After reset, reads with the gate open return 0xFFFFFFFF at word addresses 0x1C to 0x1F, 0x04000000 at 0x20, and 0 at every other word address. Both the transmitter and the receiver are stopped after reset.
- R2: Writing 4 to the enable word (0x18) opens the gate, and any other nonzero value is ignored. Writing 0 closes the gate, stops the transmitter and the receiver, and sets the receiver-stopped event, even when the gate is already closed.
- R3: With the gate closed, every read returns 0 and every write other than to the enable word has no effect.
- R4: Task words take effect only when the value written is exactly 1. Start-receive (0x00) and start-transmit (0x02) start their sides. Stop-receive (0x01) stops the receiver and sets the receiver-stopped event. Stop-transmit (0x03) stops only the transmitter and leaves that event unchanged. Suspend (0x04) stops both sides and sets the event.
- R5: `irq` is high exactly when some event is set and its mask bit is set, using bit 0 for received byte, bit 1 for transmit done, bit 2 for error and bit 3 for receiver stopped. It follows any change from the clock edge of the write.
- R6: Mask word 0x10 is written whole, 0x11 ORs the written value into the mask, and 0x12 clears the mask bits written as 1. A read of any of the three words returns the whole mask.
- R7: The error-source word (0x14) is write-one-to-clear. A `line_break` pulse sets its bits 1:0 and the error event (0x0A).
- R8: A write to the transmit word (0x1A) is taken only while the transmitter runs and no byte is pending. It raises `tx_req` with the byte on `tx_byte`. A `tx_done` pulse drops `tx_req` and sets the transmit-done event (0x09).
- R9: The received-byte event (0x08) is cleared only by writing 0 to it, and a nonzero write leaves it unchanged. Writes to the receive word (0x19) are ignored. The events at 0x09 to 0x0B take 1 for a nonzero write and 0 for zero, and every event reads back in bit 0.
- R10: Received bytes are queued while the receiver runs and the FIFO has room, which `rx_ready` shows. A read of 0x19 returns the oldest byte and removes it. A removal that leaves bytes behind sets the received-byte event again.
- R11: Read data appears on `rdata` one cycle after the read strobe. Word addresses with no function (0x28 to 0x3F, for example) keep and return the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | A transmit byte is pending |
| tx_byte | output | 8 | The pending transmit byte |
| tx_done | input | 1 | The serial engine has finished the pending byte |
| rx_valid | input | 1 | A received byte is offered |
| rx_byte | input | 8 | The received byte |
| rx_ready | output | 1 | The receiver runs and the FIFO has room |
| line_break | input | 1 | A break condition was seen on the line |

## Verification
Most internal state surfaces at a port within a cycle. A lost or stuck event appears on `irq` on the cycle after the edge once its mask bit is set, and a wrong run flag shows on `rx_ready` or as a transmit write that does not raise `tx_req`. A corrupted FIFO pointer or count shows only when bytes are read back, as bytes out of order or a missed end of queue. For that reason the bench fills the queue to its limit and drains it. A gate that opens on the wrong value shows on the next read, which returns data instead of 0.

// File: rtl/tevu_pkg.sv
package tevu_pkg;

    localparam int ADDR_W = 6;
    localparam int NUM_WORDS = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] waddr_t;

    // event flags; bit order matches the interrupt mask bits
    typedef struct packed {
        logic rxto;
        logic err;
        logic txrdy;
        logic rxrdy;
    } ev_t;

    localparam waddr_t A_RX_START = 6'h00;
    localparam waddr_t A_RX_STOP  = 6'h01;
    localparam waddr_t A_TX_START = 6'h02;
    localparam waddr_t A_TX_STOP  = 6'h03;
    localparam waddr_t A_SUSPEND  = 6'h04;
    localparam waddr_t A_EV_RXRDY = 6'h08;
    localparam waddr_t A_EV_TXRDY = 6'h09;
    localparam waddr_t A_EV_ERR   = 6'h0A;
    localparam waddr_t A_EV_RXTO  = 6'h0B;
    localparam waddr_t A_IE       = 6'h10;
    localparam waddr_t A_IE_SET   = 6'h11;
    localparam waddr_t A_IE_CLR   = 6'h12;
    localparam waddr_t A_ERRSRC   = 6'h14;
    localparam waddr_t A_ENABLE   = 6'h18;
    localparam waddr_t A_RXDATA   = 6'h19;
    localparam waddr_t A_TXDATA   = 6'h1A;
    localparam waddr_t A_PIN_LO   = 6'h1C;
    localparam waddr_t A_PIN_HI   = 6'h1F;
    localparam waddr_t A_BAUD     = 6'h20;

    localparam logic [31:0] ENABLE_KEY = 32'd4;

    function automatic logic [31:0] reset_word(input waddr_t a);
        if (a >= A_PIN_LO && a <= A_PIN_HI) return 32'hFFFF_FFFF;
        if (a == A_BAUD) return 32'h0400_0000;
        return 32'h0;
    endfunction

endpackage

// File: rtl/tevu_rx_fifo.sv
module tevu_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = store[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/tevu_tx_slot.sv
module tevu_tx_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         done,
    output logic         busy,
    output logic [W-1:0] dout,
    output logic         done_ev
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            dout <= '0;
        end else if (load) begin
            busy <= 1'b1;
            dout <= din;
        end else if (done) begin
            busy <= 1'b0;
        end
    end

    assign done_ev = done && busy;
endmodule

// File: rtl/tevu_irq_gen.sv
module tevu_irq_gen #(
    parameter int N = 4
) (
    input  logic [N-1:0] ev,
    input  logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] term;

    for (genvar i = 0; i < N; i++) begin : g_term
        assign term[i] = ev[i] & mask[i];
    end

    assign irq = |term;
endmodule

// File: rtl/tevu_ctrl.sv
module tevu_ctrl
    import tevu_pkg::*;
#(
    parameter int RX_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [5:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        tx_req,
    output logic [7:0]  tx_byte,
    input  logic        tx_done,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        rx_ready,
    input  logic        line_break
);
    localparam int CNT_W = $clog2(RX_DEPTH + 1);
    localparam int EV_N  = $bits(ev_t);

    logic        en_q, rx_run, tx_run;
    ev_t         ev_q;
    logic [EV_N-1:0] ev_vec;
    logic [31:0] ie_q, errsrc_q;
    logic [31:0] mem [NUM_WORDS];
    logic [31:0] rd_mux;

    logic             wr_on, push, pop, tx_load, tx_fin;
    logic [7:0]       fifo_dout;
    logic             fifo_full, fifo_empty;
    logic [CNT_W-1:0] rx_cnt;

    assign wr_on    = wr_en && (en_q || addr == A_ENABLE);
    assign rx_ready = rx_run && !fifo_full;
    assign push     = rx_valid && rx_ready;
    assign pop      = rd_en && en_q && addr == A_RXDATA && rx_run && !fifo_empty;
    assign tx_load  = wr_on && addr == A_TXDATA && tx_run && !tx_req;
    assign ev_vec   = ev_q;

    tevu_rx_fifo #(.DEPTH(RX_DEPTH), .W(8), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(rx_byte), .pop(pop),
        .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty), .count(rx_cnt)
    );

    tevu_tx_slot #(.W(8)) u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .din(wdata[7:0]), .done(tx_done),
        .busy(tx_req), .dout(tx_byte), .done_ev(tx_fin)
    );

    tevu_irq_gen #(.N(EV_N)) u_irq (
        .ev(ev_vec), .mask(ie_q[EV_N-1:0]), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            rx_run   <= 1'b0;
            tx_run   <= 1'b0;
            ev_q     <= '0;
            ie_q     <= '0;
            errsrc_q <= '0;
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= reset_word(waddr_t'(i));
        end else begin
            if (wr_on) begin
                case (addr)
                    A_RX_START: if (wdata == 32'd1) rx_run <= 1'b1;
                    A_TX_START: if (wdata == 32'd1) tx_run <= 1'b1;
                    A_RX_STOP: if (wdata == 32'd1) begin
                        rx_run    <= 1'b0;
                        ev_q.rxto <= 1'b1;
                    end
                    A_TX_STOP: if (wdata == 32'd1) tx_run <= 1'b0;
                    A_SUSPEND: if (wdata == 32'd1) begin
                        rx_run    <= 1'b0;
                        tx_run    <= 1'b0;
                        ev_q.rxto <= 1'b1;
                    end
                    A_EV_RXRDY: if (wdata == 32'd0) ev_q.rxrdy <= 1'b0;
                    A_EV_TXRDY: ev_q.txrdy <= |wdata;
                    A_EV_ERR:   ev_q.err   <= |wdata;
                    A_EV_RXTO:  ev_q.rxto  <= |wdata;
                    A_IE:       ie_q <= wdata;
                    A_IE_SET:   ie_q <= ie_q | wdata;
                    A_IE_CLR:   ie_q <= ie_q & ~wdata;
                    A_ERRSRC:   errsrc_q <= errsrc_q & ~wdata;
                    A_ENABLE: begin
                        if (wdata == ENABLE_KEY) begin
                            en_q <= 1'b1;
                        end else if (wdata == 32'd0) begin
                            en_q      <= 1'b0;
                            rx_run    <= 1'b0;
                            tx_run    <= 1'b0;
                            ev_q.rxto <= 1'b1;
                        end
                    end
                    A_RXDATA, A_TXDATA: ;
                    default: mem[addr] <= wdata;
                endcase
            end
            // hardware-side sets come last so they win over a same-cycle write
            if (push || (pop && rx_cnt > CNT_W'(1))) ev_q.rxrdy <= 1'b1;
            if (tx_fin) ev_q.txrdy <= 1'b1;
            if (line_break) begin
                errsrc_q[1:0] <= 2'b11;
                ev_q.err      <= 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            A_RX_START, A_RX_STOP, A_TX_START, A_TX_STOP, A_SUSPEND: rd_mux = '0;
            A_EV_RXRDY: rd_mux = {31'b0, ev_q.rxrdy};
            A_EV_TXRDY: rd_mux = {31'b0, ev_q.txrdy};
            A_EV_ERR:   rd_mux = {31'b0, ev_q.err};
            A_EV_RXTO:  rd_mux = {31'b0, ev_q.rxto};
            A_IE, A_IE_SET, A_IE_CLR: rd_mux = ie_q;
            A_ERRSRC:   rd_mux = errsrc_q;
            A_ENABLE:   rd_mux = en_q ? ENABLE_KEY : 32'h0;
            A_RXDATA:   rd_mux = {24'b0, fifo_dout};
            A_TXDATA:   rd_mux = {24'b0, tx_byte};
            default:    rd_mux = mem[addr];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= en_q ? rd_mux : '0;
    end
endmodule

// File: rtl/tevu_ctrl_chk.sv
module tevu_ctrl_chk
    import tevu_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [5:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             irq,
    input logic             tx_req,
    input logic             tx_done,
    input logic             line_break,
    input logic             en_q,
    input logic             rx_run,
    input logic [3:0]       ev_vec,
    input logic [1:0]       errsrc_lo,
    input logic [CNT_W-1:0] rx_cnt
);
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CNT_W'(DEPTH)); // R10

    AST_ENABLE_MAGIC: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(wr_en && addr == A_ENABLE && wdata == ENABLE_KEY)); // R2

    AST_CLOSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(en_q)) |-> rdata == 32'h0); // R3

    AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_req) |-> $past(wr_en && en_q && addr == A_TXDATA)); // R8

    AST_TX_DONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done) |=> (ev_vec[1] && !tx_req)); // R8

    AST_BREAK_LATCH: assert property (@(posedge clk) disable iff (rst)
        line_break |=> (errsrc_lo == 2'b11 && ev_vec[2])); // R7

    AST_STOP_RX: assert property (@(posedge clk) disable iff (rst)
        (wr_en && en_q && addr == A_RX_STOP && wdata == 32'd1) |=> (!rx_run && ev_vec[3])); // R4

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ev_vec != 4'b0)); // R5
endmodule

bind tevu_ctrl tevu_ctrl_chk #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_req(tx_req),
    .tx_done(tx_done), .line_break(line_break), .en_q(en_q),
    .rx_run(rx_run), .ev_vec(ev_vec), .errsrc_lo(errsrc_q[1:0]),
    .rx_cnt(rx_cnt)
);

// File: tb/sim_tevu_ctrl.sv
module sim_tevu_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, tx_req, rx_ready;
    logic [7:0]  tx_byte;
    logic        tx_done = 1'b0, rx_valid = 1'b0, line_break = 1'b0;
    logic [7:0]  rx_byte = '0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [31:0] got;
    logic [31:0] mask_m;
    logic [31:0] scratch_m [24];

    always #2.5 clk = ~clk;

    tevu_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .tx_req(tx_req),
        .tx_byte(tx_byte), .tx_done(tx_done), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .line_break(line_break)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_break();
        @(negedge clk); line_break = 1'b1;
        @(negedge clk); line_break = 1'b0;
    endtask

    function automatic logic [31:0] mask_op(input int op, input logic [31:0] m, input logic [31:0] v);
        case (op)
            0:       return v;
            1:       return m | v;
            default: return m & ~v;
        endcase
    endfunction

    function automatic logic [31:0] reset_expect(input int a);
        if (a >= 'h1C && a <= 'h1F) return 32'hFFFF_FFFF;
        if (a == 'h20) return 32'h0400_0000;
        return 32'h0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 tx_req", {31'b0, tx_req}, 32'h0);
        check("R1 rx_ready", {31'b0, rx_ready}, 32'h0);

        // closed gate
        rd(6'h20, got);             check("R3 closed read", got, 32'h0);
        wr(6'h10, 32'hF);           // ignored
        wr(6'h00, 32'h1);           // ignored start-receive
        check("R3 closed task", {31'b0, rx_ready}, 32'h0);
        wr(6'h18, 32'h5);           // non-key value
        rd(6'h20, got);             check("R2 wrong key", got, 32'h0);
        wr(6'h18, 32'h4);
        rd(6'h18, got);             check("R2 key opens", got, 32'h4);
        for (int a = 0; a < 64; a++) begin
            if (a == 'h18 || a == 'h19 || a == 'h1A) continue;
            rd(6'(a), got);
            check("R1 reset word", got, reset_expect(a));
        end
        rd(6'h10, got);             check("R3 mask unchanged", got, 32'h0);

        // mask write/set/clear
        wr(6'h10, 32'h5); wr(6'h11, 32'h2); wr(6'h12, 32'h4);
        rd(6'h11, got);             check("R6 via set word", got, 32'h3);
        rd(6'h12, got);             check("R6 via clear word", got, 32'h3);
        mask_m = 32'h3;
        for (int i = 0; i < 30; i++) begin
            int op = int'($urandom % 3);
            logic [31:0] v = $urandom;
            wr(6'(6'h10 + op), v);
            mask_m = mask_op(op, mask_m, v);
            rd(6'h10, got);
            check("R6 random mask", got, mask_m);
        end
        wr(6'h10, 32'h3);

        // transmit
        wr(6'h02, 32'h1); wr(6'h03, 32'h1);
        rd(6'h0B, got);             check("R4 stop-tx no event", got, 32'h0);
        wr(6'h1A, 32'h55);          check("R8 stopped tx", {31'b0, tx_req}, 32'h0);
        wr(6'h02, 32'h2);
        wr(6'h1A, 32'h55);          check("R4 task needs 1", {31'b0, tx_req}, 32'h0);
        wr(6'h02, 32'h1);
        wr(6'h1A, 32'h5A);
        check("R8 tx_req", {31'b0, tx_req}, 32'h1);
        check("R8 tx_byte", {24'b0, tx_byte}, 32'h5A);
        wr(6'h1A, 32'h77);          check("R8 pending holds", {24'b0, tx_byte}, 32'h5A);
        check("R5 no irq yet", {31'b0, irq}, 32'h0);
        pulse_done();
        check("R8 done drops", {31'b0, tx_req}, 32'h0);
        check("R5 tx irq", {31'b0, irq}, 32'h1);
        wr(6'h09, 32'h0);           check("R5 irq clears", {31'b0, irq}, 32'h0);

        // receive
        wr(6'h00, 32'h1);           check("R4 start-rx", {31'b0, rx_ready}, 32'h1);
        push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
        check("R5 rx irq", {31'b0, irq}, 32'h1);
        wr(6'h08, 32'h1);
        rd(6'h08, got);             check("R9 nonzero keeps", got, 32'h1);
        wr(6'h19, 32'h99);
        wr(6'h08, 32'h0);           check("R9 zero clears", {31'b0, irq}, 32'h0);
        rd(6'h19, got);             check("R10 first byte", got, 32'h11);
        check("R10 event re-set", {31'b0, irq}, 32'h1);
        rd(6'h19, got);             check("R9 rxdata write ignored", got, 32'h22);
        wr(6'h08, 32'h0);
        rd(6'h19, got);             check("R10 last byte", got, 32'h33);
        rd(6'h08, got);             check("R10 empty no event", got, 32'h0);
        for (int i = 0; i < 4; i++) push_rx(8'(8'hA0 + i));
        check("R10 full", {31'b0, rx_ready}, 32'h0);
        push_rx(8'hEE);
        for (int i = 0; i < 4; i++) begin
            rd(6'h19, got);
            check("R10 order", got, 32'(8'hA0 + i));
        end
        check("R10 room again", {31'b0, rx_ready}, 32'h1);
        wr(6'h08, 32'h0);

        // stop and suspend
        wr(6'h11, 32'h8);
        check("R5 masked quiet", {31'b0, irq}, 32'h0);
        wr(6'h01, 32'h1);
        check("R4 stop-rx", {31'b0, rx_ready}, 32'h0);
        check("R5 rxto irq", {31'b0, irq}, 32'h1);
        wr(6'h0B, 32'h0);           check("R9 rxto cleared", {31'b0, irq}, 32'h0);
        wr(6'h00, 32'h1); wr(6'h02, 32'h1); wr(6'h04, 32'h1);
        check("R4 suspend rx", {31'b0, rx_ready}, 32'h0);
        rd(6'h0B, got);             check("R4 suspend event", got, 32'h1);
        wr(6'h1A, 32'h42);          check("R4 suspend tx", {31'b0, tx_req}, 32'h0);
        wr(6'h0B, 32'h0);

        // break and error source
        pulse_break();
        rd(6'h14, got);             check("R7 break bits", got, 32'h3);
        rd(6'h0A, got);             check("R7 error event", got, 32'h1);
        wr(6'h14, 32'h1);
        rd(6'h14, got);             check("R7 w1c", got, 32'h2);
        wr(6'h14, 32'h2);
        rd(6'h14, got);             check("R7 w1c all", got, 32'h0);

        // plain storage words
        for (int i = 0; i < 24; i++) scratch_m[i] = 32'h0;
        for (int i = 0; i < 40; i++) begin
            int k = int'($urandom % 24);
            if ($urandom % 2) begin
                logic [31:0] v = $urandom;
                wr(6'(6'h28 + k), v);
                scratch_m[k] = v;
            end else begin
                rd(6'(6'h28 + k), got);
                check("R11 stored word", got, scratch_m[k]);
            end
        end

        // closing the gate
        wr(6'h00, 32'h1); wr(6'h02, 32'h1);
        wr(6'h18, 32'h0);
        check("R2 close stops rx", {31'b0, rx_ready}, 32'h0);
        check("R2 close sets event", {31'b0, irq}, 32'h1);
        rd(6'h10, got);             check("R3 closed mask read", got, 32'h0);
        wr(6'h18, 32'h4);
        wr(6'h1A, 32'h42);          check("R2 close stops tx", {31'b0, tx_req}, 32'h0);
        rd(6'h0B, got);             check("R2 event held", got, 32'h1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule